// File: doc/BRIEF.md
# Load Queue with Store-Ordering Check

This block keeps the in-flight loads of an out-of-order core in a circular queue, in program order. Each allocated load gets a queue index, carries a sequence number, and later receives its effective address through a separate update port. When a store executes, the core presents the store's address together with the load-queue position that was current when the store was inserted. All loads from that position up to the tail are compared with the store at a coarse granularity, where the low address bits are ignored. The first load that matches is latched as a memory-ordering violator, and a fault pulse is returned.

Loads leave the queue from either end. A commit frees entries at the head whose sequence numbers are not younger than a supplied bound. A squash frees entries at the tail whose sequence numbers are younger than a squash point. Both may free several entries in one cycle. The block also reports how many more memory operations can be accepted, taking a sibling store queue's occupancy into account. On each allocation it gives the store-queue position the load must later check against.

Top module: `ldq_order_check`

## Requirements
- R1: After reset the queue is empty, `alloc_idx_o` is 0, `alloc_ready_o` is 1 and `viol_valid_o` is 0.
- R2: An accepted allocation writes at index `alloc_idx_o`, and the index then advances by one, wrapping from DEPTH-1 to 0. `alloc_ready_o` is 0 while DEPTH-1 entries are held, because one slot always stays unused, and a request made while it is 0 changes nothing.
- R3: `alloc_sq_pos_o` equals `sq_tail_i` zero-extended when `sq_count_i` is non-zero, and all ones (the value -1) when it is zero.
- R4: `free_o` equals min(DEPTH - occupancy, SQ_DEPTH - `sq_count_i`) - 1, floored at 0.
- R5: A store check compares the loads from index `chk_lq_pos_i` up to, but not including, the tail, following the wrap. Addresses match when they are equal after the low GRAN_BITS (8) bits are dropped. A load whose address has not been supplied never matches, and an empty window never matches.
- R6: The matching load nearest to `chk_lq_pos_i` in queue order is latched into `viol_idx_o`/`viol_seq_o` with `viol_valid_o`. `chk_fault_o` is high for exactly the one cycle after such a check.
- R7: While `viol_valid_o` is 1, store checks are skipped, with no fault and an unchanged violator. Asserting `viol_read_i` clears `viol_valid_o` at the next edge.
- R8: A commit frees entries from the head while the queue is non-empty and the head's sequence number is less than or equal to `commit_seq_i`.
- R9: A squash frees entries from the tail backwards while the queue is non-empty and the tail entry's sequence number is greater than `squash_seq_i`. Allocation is refused during the squash cycle, and the next allocation reuses the freed index.
- R10: Moving the tail back past index 0 wraps it to DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Allocation request |
| alloc_seq_i | input | SEQ_W | Sequence number of the new load |
| alloc_ready_o | output | 1 | Allocation can be accepted |
| alloc_idx_o | output | IDX_W | Index the next load will occupy |
| alloc_sq_pos_o | output | SQ_IDX_W+1 | Store-queue position recorded for the new load (all ones when the store queue is empty) |
| sq_tail_i | input | SQ_IDX_W | Store-queue tail index |
| sq_count_i | input | SQ_CNT_W | Store-queue occupancy |
| addr_valid_i | input | 1 | Effective-address update strobe |
| addr_idx_i | input | IDX_W | Entry that receives the address |
| addr_i | input | ADDR_W | Effective address of the load |
| chk_valid_i | input | 1 | Store check request |
| chk_lq_pos_i | input | IDX_W | Load-queue position captured when the store was inserted |
| chk_addr_i | input | ADDR_W | Store effective address |
| chk_fault_o | output | 1 | Ordering-violation pulse, one cycle after the check |
| viol_valid_o | output | 1 | A violator is held |
| viol_idx_o | output | IDX_W | Index of the held violator |
| viol_seq_o | output | SEQ_W | Sequence number of the held violator |
| viol_read_i | input | 1 | Consumes and clears the held violator |
| commit_valid_i | input | 1 | Commit request |
| commit_seq_i | input | SEQ_W | Youngest committed sequence number |
| squash_valid_i | input | 1 | Squash request |
| squash_seq_i | input | SEQ_W | Loads younger than this are removed |
| free_o | output | FREE_W | Memory operations that can still be accepted |

## Verification
`alloc_idx_o`, `alloc_ready_o` and `free_o` come combinationally from the pointer and occupancy registers, so they take their new values right after the edge that takes an allocation, commit or squash. `chk_fault_o` and the violator registers update on the edge that samples the check, and a read clears the violator on the edge that samples it. The bench drives each stimulus just after a falling edge and samples at the following falling edge, which is one rising edge later. It checks the combinational `alloc_ready_o` during the squash cycle itself, before that rising edge. The vector table covers the window bounds, granularity masking, missing addresses and nearest-first priority; directed steps cover wrap, full, squash and commit.

// File: rtl/ldq_pkg.sv
package ldq_pkg;

  typedef enum logic {WALK_FWD, WALK_BWD} walk_dir_e;

  // distance travelled forward from from_idx to to_idx on a ring of depth
  function automatic int fwd_dist(int from_idx, int to_idx, int depth);
    return (to_idx >= from_idx) ? (to_idx - from_idx) : (to_idx + depth - from_idx);
  endfunction

  // single-wrap correction, valid for raw in [-depth, 2*depth)
  function automatic int wrap_idx(int raw, int depth);
    if (raw >= depth) return raw - depth;
    if (raw < 0) return raw + depth;
    return raw;
  endfunction

endpackage

// File: rtl/ldq_match_vec.sv
module ldq_match_vec #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 24
) (
  input  logic [DEPTH-1:0][TAG_W-1:0] ent_tag_i,
  input  logic [DEPTH-1:0]            ent_tag_vld_i,
  input  logic [DEPTH-1:0]            window_i,
  input  logic [TAG_W-1:0]            st_tag_i,
  output logic [DEPTH-1:0]            hit_o
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign hit_o[g] = window_i[g] & ent_tag_vld_i[g] & (ent_tag_i[g] == st_tag_i);
  end

endmodule

// File: rtl/ldq_first_pick.sv
module ldq_first_pick #(
  parameter  int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] hit_i,
  input  logic [IDX_W-1:0] start_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);

  // nearest hit walking forward from start_i
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      int p;
      p = ldq_pkg::wrap_idx(int'(start_i) + k, DEPTH);
      if (!found_o && hit_i[p]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(p);
      end
    end
  end

endmodule

// File: rtl/ldq_run_len.sv
module ldq_run_len #(
  parameter  int                DEPTH = 8,
  parameter  ldq_pkg::walk_dir_e DIR  = ldq_pkg::WALK_FWD,
  localparam int                IDX_W = $clog2(DEPTH),
  localparam int                CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0] cond_i,
  input  logic [IDX_W-1:0] base_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] run_o
);

  localparam int STEP = (DIR == ldq_pkg::WALK_FWD) ? 1 : -1;

  // length of the unbroken run of live entries satisfying cond_i from base_i
  always_comb begin
    logic open_run;
    open_run = 1'b1;
    run_o    = '0;
    for (int k = 0; k < DEPTH; k++) begin
      int p;
      p = ldq_pkg::wrap_idx(int'(base_i) + STEP * k, DEPTH);
      if (open_run && (k < int'(count_i)) && cond_i[p]) run_o = run_o + CNT_W'(1);
      else open_run = 1'b0;
    end
  end

endmodule

// File: rtl/ldq_order_check.sv
module ldq_order_check #(
  parameter  int DEPTH     = 8,
  parameter  int SQ_DEPTH  = 8,
  parameter  int SEQ_W     = 16,
  parameter  int ADDR_W    = 32,
  parameter  int GRAN_BITS = 8,
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int CNT_W     = $clog2(DEPTH + 1),
  localparam int SQ_IDX_W  = $clog2(SQ_DEPTH),
  localparam int SQ_CNT_W  = $clog2(SQ_DEPTH + 1),
  localparam int FREE_W    = (CNT_W > SQ_CNT_W) ? CNT_W : SQ_CNT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                alloc_valid_i,
  input  logic [SEQ_W-1:0]    alloc_seq_i,
  output logic                alloc_ready_o,
  output logic [IDX_W-1:0]    alloc_idx_o,
  output logic [SQ_IDX_W:0]   alloc_sq_pos_o,
  input  logic [SQ_IDX_W-1:0] sq_tail_i,
  input  logic [SQ_CNT_W-1:0] sq_count_i,
  input  logic                addr_valid_i,
  input  logic [IDX_W-1:0]    addr_idx_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                chk_valid_i,
  input  logic [IDX_W-1:0]    chk_lq_pos_i,
  input  logic [ADDR_W-1:0]   chk_addr_i,
  output logic                chk_fault_o,
  output logic                viol_valid_o,
  output logic [IDX_W-1:0]    viol_idx_o,
  output logic [SEQ_W-1:0]    viol_seq_o,
  input  logic                viol_read_i,
  input  logic                commit_valid_i,
  input  logic [SEQ_W-1:0]    commit_seq_i,
  input  logic                squash_valid_i,
  input  logic [SEQ_W-1:0]    squash_seq_i,
  output logic [FREE_W-1:0]   free_o
);

  localparam int TAG_W = ADDR_W - GRAN_BITS;

  // entry state
  logic [DEPTH-1:0][SEQ_W-1:0] seq_q;
  logic [DEPTH-1:0][TAG_W-1:0] tag_q;
  logic [DEPTH-1:0]            tag_vld_q;
  logic [IDX_W-1:0]            head_q, tail_q;
  logic [CNT_W-1:0]            cnt_q;

  // violator holding register
  logic                        viol_valid_q;
  logic [IDX_W-1:0]            viol_idx_q;
  logic [SEQ_W-1:0]            viol_seq_q;
  logic                        fault_q;

  logic unused_addr_low;
  assign unused_addr_low = ^{addr_i[GRAN_BITS-1:0], chk_addr_i[GRAN_BITS-1:0]};

  // per-entry qualifiers
  logic [DEPTH-1:0] live, window, commit_ok, squash_ok;
  int               chk_span;
  assign chk_span = ldq_pkg::fwd_dist(int'(chk_lq_pos_i), int'(tail_q), DEPTH);

  for (genvar g = 0; g < DEPTH; g++) begin : g_qual
    assign live[g]      = ldq_pkg::fwd_dist(int'(head_q), g, DEPTH) < int'(cnt_q);
    assign window[g]    = live[g] && (ldq_pkg::fwd_dist(int'(chk_lq_pos_i), g, DEPTH) < chk_span);
    assign commit_ok[g] = seq_q[g] <= commit_seq_i;
    assign squash_ok[g] = seq_q[g] > squash_seq_i;
  end

  // store check
  logic [DEPTH-1:0] hit;
  logic             pick_found;
  logic [IDX_W-1:0] pick_idx;
  logic             do_chk;

  ldq_match_vec #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_match (
    .ent_tag_i     (tag_q),
    .ent_tag_vld_i (tag_vld_q),
    .window_i      (window),
    .st_tag_i      (chk_addr_i[ADDR_W-1:GRAN_BITS]),
    .hit_o         (hit)
  );

  ldq_first_pick #(.DEPTH(DEPTH)) u_pick (
    .hit_i   (hit),
    .start_i (chk_lq_pos_i),
    .found_o (pick_found),
    .idx_o   (pick_idx)
  );

  assign do_chk = chk_valid_i && !viol_valid_q;

  // retire run lengths
  logic [IDX_W-1:0] squash_base;
  logic [CNT_W-1:0] cm_run, sq_run, sq_n, cm_n, remain;

  assign squash_base = IDX_W'(ldq_pkg::wrap_idx(int'(tail_q) - 1, DEPTH));

  ldq_run_len #(.DEPTH(DEPTH), .DIR(ldq_pkg::WALK_FWD)) u_run_commit (
    .cond_i  (commit_ok),
    .base_i  (head_q),
    .count_i (cnt_q),
    .run_o   (cm_run)
  );

  ldq_run_len #(.DEPTH(DEPTH), .DIR(ldq_pkg::WALK_BWD)) u_run_squash (
    .cond_i  (squash_ok),
    .base_i  (squash_base),
    .count_i (cnt_q),
    .run_o   (sq_run)
  );

  // squash and commit in one cycle never free the same entry
  always_comb begin
    sq_n   = squash_valid_i ? sq_run : '0;
    remain = cnt_q - sq_n;
    cm_n   = '0;
    if (commit_valid_i) cm_n = (cm_run < remain) ? cm_run : remain;
  end

  // allocation
  logic do_alloc;
  assign alloc_ready_o  = (cnt_q != CNT_W'(DEPTH - 1)) && !squash_valid_i;
  assign do_alloc       = alloc_valid_i && alloc_ready_o;
  assign alloc_idx_o    = tail_q;
  assign alloc_sq_pos_o = (sq_count_i == '0) ? '1 : {1'b0, sq_tail_i};

  // pointer next state
  logic [IDX_W-1:0] head_d, tail_d;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    head_d = IDX_W'(ldq_pkg::wrap_idx(int'(head_q) + int'(cm_n), DEPTH));
    tail_d = IDX_W'(ldq_pkg::wrap_idx(int'(tail_q) - int'(sq_n) + (do_alloc ? 1 : 0), DEPTH));
    cnt_d  = cnt_q - sq_n - cm_n + CNT_W'(do_alloc);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  // entry writes; allocation wins over an address update to the same slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q     <= '0;
      tag_q     <= '0;
      tag_vld_q <= '0;
    end else begin
      if (addr_valid_i) begin
        tag_q[addr_idx_i]     <= addr_i[ADDR_W-1:GRAN_BITS];
        tag_vld_q[addr_idx_i] <= 1'b1;
      end
      if (do_alloc) begin
        seq_q[tail_q]     <= alloc_seq_i;
        tag_vld_q[tail_q] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_valid_q <= 1'b0;
      viol_idx_q   <= '0;
      viol_seq_q   <= '0;
      fault_q      <= 1'b0;
    end else begin
      if (viol_read_i) viol_valid_q <= 1'b0;
      if (do_chk && pick_found) begin
        viol_valid_q <= 1'b1;
        viol_idx_q   <= pick_idx;
        viol_seq_q   <= seq_q[pick_idx];
      end
      fault_q <= do_chk && pick_found;
    end
  end

  assign chk_fault_o  = fault_q;
  assign viol_valid_o = viol_valid_q;
  assign viol_idx_o   = viol_idx_q;
  assign viol_seq_o   = viol_seq_q;

  // free slots, one held back on each queue
  logic [FREE_W-1:0] lq_free, sq_free, min_free;
  always_comb begin
    lq_free  = FREE_W'(CNT_W'(DEPTH) - cnt_q);
    sq_free  = FREE_W'(SQ_CNT_W'(SQ_DEPTH) - sq_count_i);
    min_free = (lq_free < sq_free) ? lq_free : sq_free;
    free_o   = (min_free == '0) ? '0 : min_free - FREE_W'(1);
  end

endmodule

// File: rtl/ldq_order_check_chk.sv
module ldq_order_check_chk #(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 4,
  parameter int FREE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              alloc_valid_i,
  input logic              alloc_ready_o,
  input logic              commit_valid_i,
  input logic              squash_valid_i,
  input logic              chk_valid_i,
  input logic              chk_fault_o,
  input logic              viol_valid_o,
  input logic [IDX_W-1:0]  viol_idx_o,
  input logic [SEQ_W-1:0]  viol_seq_o,
  input logic              viol_read_i,
  input logic [FREE_W-1:0] free_o,
  input logic [CNT_W-1:0]  cnt_q
);

  assert_occ_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH - 1));

  assert_full_refuse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(DEPTH - 1)) |-> !alloc_ready_o);

  assert_alloc_grow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && alloc_ready_o && !commit_valid_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  assert_squash_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_valid_i |-> !alloc_ready_o);

  assert_free_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(free_o) + int'(cnt_q) <= DEPTH - 1);

  assert_fault_latched_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_fault_o |-> viol_valid_o);

  assert_no_fault_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_valid_i |=> !chk_fault_o);

  assert_pending_skip_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_valid_i && viol_valid_o) |=> !chk_fault_o);

  assert_viol_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_valid_o && !viol_read_i) |=> (viol_valid_o && $stable(viol_idx_o) && $stable(viol_seq_o)));

  assert_read_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_valid_o && viol_read_i) |=> !viol_valid_o);

endmodule

bind ldq_order_check ldq_order_check_chk #(
  .DEPTH(DEPTH), .SEQ_W(SEQ_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .FREE_W(FREE_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .alloc_valid_i  (alloc_valid_i),
  .alloc_ready_o  (alloc_ready_o),
  .commit_valid_i (commit_valid_i),
  .squash_valid_i (squash_valid_i),
  .chk_valid_i    (chk_valid_i),
  .chk_fault_o    (chk_fault_o),
  .viol_valid_o   (viol_valid_o),
  .viol_idx_o     (viol_idx_o),
  .viol_seq_o     (viol_seq_o),
  .viol_read_i    (viol_read_i),
  .free_o         (free_o),
  .cnt_q          (cnt_q)
);

// File: tb/ldq_order_check_bench.sv
module ldq_order_check_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        alloc_valid_i = 1'b0;
  logic [15:0] alloc_seq_i = '0;
  logic        alloc_ready_o;
  logic [2:0]  alloc_idx_o;
  logic [3:0]  alloc_sq_pos_o;
  logic [2:0]  sq_tail_i = '0;
  logic [3:0]  sq_count_i = '0;
  logic        addr_valid_i = 1'b0;
  logic [2:0]  addr_idx_i = '0;
  logic [31:0] addr_i = '0;
  logic        chk_valid_i = 1'b0;
  logic [2:0]  chk_lq_pos_i = '0;
  logic [31:0] chk_addr_i = '0;
  logic        chk_fault_o;
  logic        viol_valid_o;
  logic [2:0]  viol_idx_o;
  logic [15:0] viol_seq_o;
  logic        viol_read_i = 1'b0;
  logic        commit_valid_i = 1'b0;
  logic [15:0] commit_seq_i = '0;
  logic        squash_valid_i = 1'b0;
  logic [15:0] squash_seq_i = '0;
  logic [3:0]  free_o;

  always #4 clk_i = ~clk_i;

  ldq_order_check u_ldq_order_check (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic do_alloc(input logic [15:0] s);
    alloc_valid_i = 1'b1; alloc_seq_i = s; tick(); alloc_valid_i = 1'b0;
  endtask

  task automatic set_addr(input logic [2:0] idx, input logic [31:0] a);
    addr_valid_i = 1'b1; addr_idx_i = idx; addr_i = a; tick(); addr_valid_i = 1'b0;
  endtask

  task automatic do_check(input logic [2:0] pos, input logic [31:0] a);
    chk_valid_i = 1'b1; chk_lq_pos_i = pos; chk_addr_i = a; tick(); chk_valid_i = 1'b0;
  endtask

  task automatic do_read();
    viol_read_i = 1'b1; tick(); viol_read_i = 1'b0;
  endtask

  task automatic do_commit(input logic [15:0] s);
    commit_valid_i = 1'b1; commit_seq_i = s; tick(); commit_valid_i = 1'b0;
  endtask

  typedef struct packed {
    logic [2:0]  start;
    logic [31:0] addr;
    logic        fault;
    logic [2:0]  idx;
    logic [15:0] seq;
  } vec_t;

  // loads at idx0..5: seq 10..15, addr 0x1000,0x2000,0x1234,none,0x12FF,0x3400
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'h0000_12AB, 1'b1, 3'd2, 16'd12},
    '{3'd3, 32'h0000_1200, 1'b1, 3'd4, 16'd14},
    '{3'd5, 32'h0000_12FF, 1'b0, 3'd0, 16'd0},
    '{3'd0, 32'h0000_3499, 1'b1, 3'd5, 16'd15},
    '{3'd6, 32'h0000_1000, 1'b0, 3'd0, 16'd0},
    '{3'd1, 32'h0000_1080, 1'b0, 3'd0, 16'd0},
    '{3'd1, 32'h0000_20FF, 1'b1, 3'd1, 16'd11},
    '{3'd3, 32'h0000_0000, 1'b0, 3'd0, 16'd0}
  };

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();

    // R1 reset state
    check("R1 alloc_idx", 32'(alloc_idx_o), 0);
    check("R1 ready", 32'(alloc_ready_o), 1);
    check("R1 viol_valid", 32'(viol_valid_o), 0);
    check("R4 free empty", 32'(free_o), 7);
    check("R3 sq empty marker", 32'(alloc_sq_pos_o), 4'hF);

    // R3 / R4 with store-queue occupancy
    sq_count_i = 4'd2; sq_tail_i = 3'd5; #1;
    check("R3 sq tail", 32'(alloc_sq_pos_o), 5);
    check("R4 free sq limited", 32'(free_o), 5);
    sq_count_i = 4'd8; #1;
    check("R4 free floor", 32'(free_o), 0);
    sq_count_i = 4'd0;
    tick();

    // R2 fill six loads
    for (int k = 0; k < 6; k++) begin
      check("R2 alloc idx", 32'(alloc_idx_o), 32'(k));
      do_alloc(16'(10 + k));
    end
    check("R4 free six held", 32'(free_o), 1);
    set_addr(3'd0, 32'h1000);
    set_addr(3'd1, 32'h2000);
    set_addr(3'd2, 32'h1234);
    set_addr(3'd4, 32'h12FF);
    set_addr(3'd5, 32'h3400);

    // R5 R6 vector table
    for (int v = 0; v < NV; v++) begin
      do_check(VECS[v].start, VECS[v].addr);
      check($sformatf("R5 R6 vec%0d fault", v), 32'(chk_fault_o), 32'(VECS[v].fault));
      check($sformatf("R6 vec%0d viol_valid", v), 32'(viol_valid_o), 32'(VECS[v].fault));
      if (VECS[v].fault) begin
        check($sformatf("R6 vec%0d idx", v), 32'(viol_idx_o), 32'(VECS[v].idx));
        check($sformatf("R6 vec%0d seq", v), 32'(viol_seq_o), 32'(VECS[v].seq));
        do_read();
        check($sformatf("R7 vec%0d read clears", v), 32'(viol_valid_o), 0);
      end
    end

    // R6 pulse width, R7 pending skip
    do_check(3'd0, 32'h12AB);
    check("R6 fault", 32'(chk_fault_o), 1);
    tick();
    check("R6 fault one cycle", 32'(chk_fault_o), 0);
    do_check(3'd5, 32'h3400);
    check("R7 skipped fault", 32'(chk_fault_o), 0);
    check("R7 violator kept", 32'(viol_idx_o), 2);
    check("R7 still valid", 32'(viol_valid_o), 1);
    do_read();
    check("R7 cleared", 32'(viol_valid_o), 0);

    // R8 commit
    do_commit(16'd11);
    check("R8 commit two", 32'(free_o), 3);
    do_commit(16'd9);
    check("R8 commit none", 32'(free_o), 3);

    // R2 fill to full with wrap
    check("R2 idx6", 32'(alloc_idx_o), 6);
    do_alloc(16'd16);
    do_alloc(16'd17);
    check("R2 wrap to 0", 32'(alloc_idx_o), 0);
    do_alloc(16'd18);
    check("R2 full ready", 32'(alloc_ready_o), 0);
    check("R4 full free", 32'(free_o), 0);
    do_alloc(16'd99);
    check("R2 refused idx", 32'(alloc_idx_o), 1);
    check("R2 refused free", 32'(free_o), 0);

    // R5 window across wrap
    set_addr(3'd0, 32'h5500);
    do_check(3'd6, 32'h55AA);
    check("R5 wrap fault", 32'(chk_fault_o), 1);
    check("R5 wrap idx", 32'(viol_idx_o), 0);
    check("R5 wrap seq", 32'(viol_seq_o), 18);
    do_read();

    // R9 R10 squash across index 0
    squash_valid_i = 1'b1; squash_seq_i = 16'd16; #1;
    check("R9 ready low in squash", 32'(alloc_ready_o), 0);
    tick();
    squash_valid_i = 1'b0;
    check("R10 tail wrapped", 32'(alloc_idx_o), 7);
    check("R9 free after squash", 32'(free_o), 2);
    do_alloc(16'd17);
    check("R9 reuse idx", 32'(alloc_idx_o), 0);
    check("R9 free after reuse", 32'(free_o), 1);

    // R8 commit everything
    do_commit(16'd100);
    check("R8 drained free", 32'(free_o), 7);
    check("R8 drained idx", 32'(alloc_idx_o), 0);
    do_check(3'd0, 32'h12AB);
    check("R5 empty window", 32'(chk_fault_o), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule